// File: doc/BRIEF.md
# Wide Memory Write Command Issuer

This block sits in front of the write port of a memory controller. It collects a stream of 64-bit words and groups every eight of them into one 512-bit write beat. For each beat it issues one command pair in a single clock cycle: a 32-bit address goes into an address FIFO and the 512-bit data goes into a data FIFO.

A start pulse sets up a job. The pulse carries a base address and a number of beats. The block then generates the address of every beat itself. Addresses are counted in 64-bit-word units, so every beat address is aligned to 512 bits and the next beat address is 8 higher.

Flow control uses the fill counts that the two FIFOs report. No push happens while either count has reached 0x1FF. While an assembled beat waits for room, the upstream ready signal stays low. A one-cycle done pulse closes each job.

Top module: `wide_wr_issuer`

## Requirements
- R1: Within a beat, the first accepted word sits in data bits [63:0] and the eighth in bits [511:448]. Lane k occupies bits [64k+63:64k].
- R2: Each beat produces exactly one cycle with `addr_we_o` high and `data_we_o` high together. The two enables are never high in different cycles.
- R3: A beat is pushed only after all eight of its words have been accepted through the `in_valid_i`/`in_ready_o` handshake.
- R4: A push occurs only while `addr_fifo_cnt_i` < 0x1FF and `data_fifo_cnt_i` < 0x1FF. A count of 0x1FE permits a push.
- R5: While a complete beat waits for FIFO room, `in_ready_o` is low and no push occurs. The held beat's data stays unchanged until it is pushed.
- R6: A start pulse accepted in idle loads the base address with its three least significant bits forced to zero. The first beat uses that address.
- R7: Each later beat address equals the previous beat address plus 8.
- R8: A job pushes exactly the requested number of beats. After the last word of the job is accepted, `in_ready_o` stays low.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last push. A start with a beat count of 0 raises `done_o` in the cycle after the start and pushes nothing.
- R10: A start pulse that arrives while a job is active is ignored. Base, count and timing of the running job are unchanged.
- R11: While `rst_ni` is low, both write enables, `in_ready_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a job (accepted only when idle) |
| base_addr_i | input | 32 | First beat address in 64-bit-word units |
| beat_num_i | input | 16 | Number of 512-bit beats in the job |
| in_data_i | input | 64 | Input word |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Block can accept a word |
| addr_fifo_cnt_i | input | 10 | Address FIFO fill count |
| data_fifo_cnt_i | input | 10 | Data FIFO fill count |
| addr_we_o | output | 1 | Address FIFO write enable |
| addr_din_o | output | 32 | Address FIFO write data |
| data_we_o | output | 1 | Data FIFO write enable |
| data_din_o | output | 512 | Data FIFO write data |
| done_o | output | 1 | One-cycle pulse after the last beat of a job |

## Verification
The assertions check the following on every cycle:
- the pairing of the two write enables;
- the fill-count gate on each push;
- alignment of the address and its step of 8;
- that a stalled beat is held stable;
- that every done pulse follows a last push or a zero-count start.

Some behaviours only the directed scenarios can show:
- the lane order inside the 512-bit word;
- the exact number of beats per job;
- the done timing relative to the last push;
- the low ready level at the 0x1FF boundary;
- that a start arriving mid-job is ignored.

// File: rtl/wmw_pkg.sv
package wmw_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned LANES   = 8;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned CNT_W   = 10;
  localparam int unsigned BEATS_W = 16;
  localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'('h1FF);

  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/wmw_packer.sv
module wmw_packer #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned LANES  = 8,
  localparam int unsigned BEAT_W = WORD_W * LANES,
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              accept_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              push_i,
  output logic              full_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  logic [IDX_W-1:0]  lane_q;
  logic              full_q;
  logic [WORD_W-1:0] lane_data_q [LANES];
  logic              last_word;

  assign last_word = accept_i && (lane_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      full_q <= 1'b0;
    end else if (clear_i) begin
      lane_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (accept_i) lane_q <= last_word ? '0 : lane_q + 1'b1;
      full_q <= (full_q && !push_i) || last_word;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_data_q[g] <= '0;
      else if (accept_i && lane_q == IDX_W'(g)) lane_data_q[g] <= word_i;
    end
    assign beat_o[g*WORD_W +: WORD_W] = lane_data_q[g];
  end

  assign full_o = full_q;

  // R5: a waiting beat keeps its content
  a_r5_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !push_i && !clear_i) |=> $stable(beat_o));
endmodule

// File: rtl/wmw_addr_gen.sv
module wmw_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 8,
  localparam int unsigned LOW_W = (STEP > 1) ? $clog2(STEP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              push_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(STEP - 1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i & ALIGN_MASK;
    else if (push_i) addr_q <= addr_q + ADDR_W'(STEP);
  end

  assign addr_o = addr_q;

  // R6: address always aligned to one beat
  a_r6_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q[LOW_W-1:0] == '0);
  // R7: one beat step per push
  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !load_i) |=> addr_q == $past(addr_q) + ADDR_W'(STEP));
endmodule

// File: rtl/wmw_seq.sv
module wmw_seq
  import wmw_pkg::*;
#(
  parameter int unsigned BEATS_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [BEATS_W-1:0] beats_i,
  input  logic               filled_i,
  input  logic               push_i,
  output logic               load_o,
  output logic               active_o,
  output logic               fill_open_o,
  output logic               done_o
);
  run_state_e         state_q;
  logic [BEATS_W-1:0] fill_left_q;
  logic [BEATS_W-1:0] push_left_q;
  logic               done_q;
  logic               last_push;

  assign load_o    = start_i && (state_q == ST_IDLE);
  assign last_push = push_i && (push_left_q == BEATS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fill_left_q <= '0;
      push_left_q <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        fill_left_q <= beats_i;
        push_left_q <= beats_i;
        if (beats_i == '0) done_q  <= 1'b1;
        else               state_q <= ST_RUN;
      end else if (state_q == ST_RUN) begin
        if (filled_i) fill_left_q <= fill_left_q - 1'b1;
        if (push_i)   push_left_q <= push_left_q - 1'b1;
        if (last_push) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign active_o    = (state_q == ST_RUN);
  assign fill_open_o = (state_q == ST_RUN) && (fill_left_q != '0);
  assign done_o      = done_q;
endmodule

// File: rtl/wide_wr_issuer.sv
module wide_wr_issuer
  import wmw_pkg::*;
#(
  parameter int unsigned DW     = wmw_pkg::WORD_W,
  parameter int unsigned NLANE  = wmw_pkg::LANES,
  parameter int unsigned AW     = wmw_pkg::ADDR_W,
  parameter int unsigned CW     = wmw_pkg::CNT_W,
  parameter int unsigned BW     = wmw_pkg::BEATS_W,
  localparam int unsigned BEAT_W = DW * NLANE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic [BW-1:0]     beat_num_i,
  input  logic [DW-1:0]     in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CW-1:0]     addr_fifo_cnt_i,
  input  logic [CW-1:0]     data_fifo_cnt_i,
  output logic              addr_we_o,
  output logic [AW-1:0]     addr_din_o,
  output logic              data_we_o,
  output logic [BEAT_W-1:0] data_din_o,
  output logic              done_o
);
  localparam logic [CW-1:0] LIMIT = CW'(ROOM_LIMIT);

  logic room, full, push, accept, load, active, fill_open, filled;

  assign room   = (addr_fifo_cnt_i < LIMIT) && (data_fifo_cnt_i < LIMIT);
  assign push   = full && room;
  assign accept = in_valid_i && in_ready_o;
  assign in_ready_o = fill_open && (!full || room);

  wmw_seq #(.BEATS_W(BW)) u_seq (
    .clk_i, .rst_ni,
    .start_i, .beats_i(beat_num_i),
    .filled_i(filled), .push_i(push),
    .load_o(load), .active_o(active), .fill_open_o(fill_open), .done_o
  );

  wmw_packer #(.WORD_W(DW), .LANES(NLANE)) u_pack (
    .clk_i, .rst_ni,
    .clear_i(load), .accept_i(accept), .word_i(in_data_i),
    .push_i(push), .full_o(full), .beat_o(data_din_o)
  );

  wmw_addr_gen #(.ADDR_W(AW), .STEP(NLANE)) u_addr (
    .clk_i, .rst_ni,
    .load_i(load), .base_i(base_addr_i), .push_i(push), .addr_o(addr_din_o)
  );

  // the packer raises full on the last lane of each beat
  logic [$clog2(NLANE+1)-1:0] lane_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lane_seen_q <= '0;
    else if (load)   lane_seen_q <= '0;
    else if (accept) lane_seen_q <= (lane_seen_q == $bits(lane_seen_q)'(NLANE-1)) ? '0 : lane_seen_q + 1'b1;
  end
  assign filled = accept && (lane_seen_q == $bits(lane_seen_q)'(NLANE-1));

  assign addr_we_o = push;
  assign data_we_o = push && active;

  // R2: both FIFOs are written in the same cycle
  a_r2_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_we_o == data_we_o);
  // R4: no push without room in both FIFOs
  a_r4_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o |-> (addr_fifo_cnt_i < LIMIT) && (data_fifo_cnt_i < LIMIT));
  // R9: done follows a final push or an empty start
  a_r9_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(addr_we_o) || $past(start_i && !active));
  // R5: no word taken while a full beat is stalled
  a_r5_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !room) |-> !in_ready_o);
endmodule

// File: tb/sim_wide_wr_issuer.sv
module sim_wide_wr_issuer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [31:0] base = '0;
  logic [15:0] beats = '0;
  logic [63:0] din = '0;
  logic valid = 0, ready;
  logic [9:0] acnt = '0, dcnt = '0;
  logic awe, dwe, done;
  logic [31:0] adin;
  logic [511:0] ddin;

  int errors = 0, checks = 0, cyc = 0;
  int n_push = 0, n_done = 0, push_cyc = -1, done_cyc = -1;
  logic [31:0]  log_addr [16];
  logic [511:0] log_data [16];

  wide_wr_issuer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .beat_num_i(beats), .in_data_i(din), .in_valid_i(valid), .in_ready_o(ready),
    .addr_fifo_cnt_i(acnt), .data_fifo_cnt_i(dcnt), .addr_we_o(awe),
    .addr_din_o(adin), .data_we_o(dwe), .data_din_o(ddin), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (awe != dwe) begin
        errors++;
        $display("FAIL R2: addr_we=%0b data_we=%0b expected equal", awe, dwe);
      end
      if (awe) begin
        if (n_push < 16) begin
          log_addr[n_push] = adin;
          log_data[n_push] = ddin;
        end
        n_push++;
        push_cyc = cyc;
      end
      if (done) begin
        n_done++;
        done_cyc = cyc;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 30000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word_of(int s, int b, int l);
    return {s[15:0], 16'hC0DE, b[15:0], l[15:0]};
  endfunction

  function automatic logic [511:0] beat_of(int s, int b);
    logic [511:0] r;
    for (int l = 0; l < 8; l++) r[l*64 +: 64] = word_of(s, b, l);
    return r;
  endfunction

  task automatic clear_log();
    n_push = 0; n_done = 0; push_cyc = -1; done_cyc = -1;
  endtask

  task automatic pulse_start(logic [31:0] a, logic [15:0] n);
    @(posedge clk); #1;
    start = 1; base = a; beats = n;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic send_word(logic [63:0] w);
    logic took;
    took = 0;
    valid = 1; din = w;
    while (!took) begin
      @(negedge clk);
      took = ready;
      @(posedge clk); #1;
    end
    valid = 0;
  endtask

  task automatic send_beat(int s, int b);
    for (int l = 0; l < 8; l++) send_word(word_of(s, b, l));
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 we", {awe, dwe}, 2'b00);
    chk("R11 ready", ready, 0);
    chk("R11 done", done, 0);
  endtask

  task automatic t_basic();
    clear_log();
    pulse_start(32'h0000_0105, 16'd3);
    for (int b = 0; b < 3; b++) send_beat(1, b);
    idle(3);
    chk("R8 beats", n_push, 3);
    chk("R6 first addr", log_addr[0], 32'h100);
    chk("R7 step", log_addr[1], 32'h108);
    chk("R7 step2", log_addr[2], 32'h110);
    chk("R1 lanes beat0", log_data[0], beat_of(1, 0));
    chk("R1 lanes beat2", log_data[2], beat_of(1, 2));
    chk("R9 done count", n_done, 1);
    chk("R9 done timing", done_cyc, push_cyc + 1);
    @(negedge clk);
    chk("R8 ready low after job", ready, 0);
  endtask

  task automatic t_partial();
    clear_log();
    pulse_start(32'h40, 16'd1);
    for (int l = 0; l < 7; l++) send_word(word_of(2, 0, l));
    idle(4);
    chk("R3 no push on 7 words", n_push, 0);
    send_word(word_of(2, 0, 7));
    idle(3);
    chk("R3 push after 8th", n_push, 1);
    chk("R1 partial data", log_data[0], beat_of(2, 0));
  endtask

  task automatic t_stall();
    clear_log();
    acnt = 10'h1FF; dcnt = 10'h000;
    pulse_start(32'h1000, 16'd2);
    send_beat(3, 0);
    idle(5);
    chk("R4 addr full blocks", n_push, 0);
    @(negedge clk);
    chk("R5 ready low stalled", ready, 0);
    chk("R5 held data", ddin, beat_of(3, 0));
    acnt = 10'h000; dcnt = 10'h1FF;
    idle(4);
    chk("R4 data full blocks", n_push, 0);
    acnt = 10'h1FE; dcnt = 10'h1FE;
    idle(2);
    chk("R4 0x1FE permits", n_push, 1);
    chk("R5 stalled beat intact", log_data[0], beat_of(3, 0));
    send_beat(3, 1);
    idle(3);
    chk("R7 stall step", log_addr[1], 32'h1008);
    chk("R9 done after stall", n_done, 1);
    acnt = '0; dcnt = '0;
  endtask

  task automatic t_zero();
    int sc;
    clear_log();
    @(posedge clk); #1;
    sc = cyc;
    start = 1; base = 32'h77; beats = 16'd0;
    @(posedge clk); #1;
    start = 0;
    idle(3);
    chk("R9 zero pushes", n_push, 0);
    chk("R9 zero done count", n_done, 1);
    chk("R9 zero done timing", done_cyc, sc + 1);
  endtask

  task automatic t_restart_ignored();
    clear_log();
    pulse_start(32'h200, 16'd2);
    for (int l = 0; l < 4; l++) send_word(word_of(4, 0, l));
    pulse_start(32'h900, 16'd5);
    for (int l = 4; l < 8; l++) send_word(word_of(4, 0, l));
    send_beat(4, 1);
    idle(3);
    chk("R10 beats kept", n_push, 2);
    chk("R10 base kept", log_addr[0], 32'h200);
    chk("R10 second addr", log_addr[1], 32'h208);
    chk("R10 data", log_data[1], beat_of(4, 1));
    chk("R10 done", n_done, 1);
    @(negedge clk);
    chk("R10 idle after", ready, 0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    @(posedge clk); #1;
    rst_n = 1;
    idle(2);
    t_basic();
    t_partial();
    t_stall();
    t_zero();
    t_restart_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule